// File: doc/BRIEF.md
# Retirement Trace Consistency Checker

This block is a synthesizable monitor placed beside a 32-bit RISC-V core. Each cycle the core may present one retirement record: a valid strobe with a 64-bit sequence index, the instruction word, halt and interrupt marks, privilege level and register-width code, source and destination register addresses and data, the program counter before and after the instruction, and the memory access address with per-byte read and write lane masks. The monitor never stalls the core. It checks each record against the interface rules only, not against instruction semantics.

Any rule broken sets a sticky flag bit. The code of the first violation and the sequence index of the record that caused it are captured and held until reset. Several flags may accumulate after that, but the captured code and index stay as they were. Records arriving while the strobe is low are ignored entirely. The first record after reset seeds the sequence and pc history. Reset is synchronous and active high.

Top module: `retire_trace_checker`

## Requirements
- R1: While `rec_valid` is low no field is examined and no state changes: flags, captured code, captured index, the expected index, the remembered pc and the halt history all stay as they were.
- R2: Every valid record after the first since reset must carry an index equal to the previous valid record's index plus one, modulo 2^64 (all-ones is followed by zero). A mismatch sets flag bit 0 (code 1). The next expected index always follows the record just seen. The first record is exempt.
- R3: A valid record with `rec_rs1_addr` zero and nonzero `rec_rs1_data` sets flag bit 2 (code 3). The same case on the second source sets flag bit 3 (code 4).
- R4: A valid record with `rec_rd_addr` zero and nonzero `rec_rd_wdata` sets flag bit 4 (code 5).
- R5: From the second valid record on, `rec_intr` must be 1 exactly when `rec_pc_rdata` differs from the previous valid record's `rec_pc_wdata`. Any other value sets flag bit 5 (code 6). The first record is exempt.
- R6: A valid record with `rec_mode` equal to 2 (the reserved level; 0 user, 1 supervisor, 3 machine) sets flag bit 6 (code 7).
- R7: A valid record with `rec_ixl` other than 1 (32-bit) sets flag bit 7 (code 8).
- R8: When either byte-lane mask is nonzero, `rec_mem_addr[1:0]` must be zero, or flag bit 8 (code 9) is set. With both masks zero the address is ignored.
- R9: An instruction word whose bits [1:0] are not 2'b11 is a 16-bit encoding, and its bits [31:16] must be zero, or flag bit 9 (code 10) is set. A word whose bits [1:0] are 2'b11 is not checked.
- R10: A valid record that arrives after a valid record with `rec_halt` set (since reset) sets flag bit 1 (code 2).
- R11: Flags are sticky until reset. Each flag appears on `err_flags` in the cycle after the clock edge that took the offending record. `err_any` is the OR of all flags.
- R12: `err_code` is 0 and `err_order` is 0 while no flag is set. The first offending record loads `err_code` with the lowest code among its violations and loads `err_order` with its index. Later violations change neither output.
- R13: Synchronous reset clears flags, code and index. It also forgets the sequence, pc and halt history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_valid | input | 1 | Record present this cycle |
| rec_order | input | 64 | Sequence index of the record |
| rec_insn | input | 32 | Instruction word |
| rec_halt | input | 1 | Last record before the core stops |
| rec_intr | input | 1 | First record of a handler (pc discontinuity) |
| rec_mode | input | 2 | Privilege level code |
| rec_ixl | input | 2 | Register width code |
| rec_rs1_addr | input | 5 | First source register address |
| rec_rs1_data | input | 32 | First source value |
| rec_rs2_addr | input | 5 | Second source register address |
| rec_rs2_data | input | 32 | Second source value |
| rec_rd_addr | input | 5 | Destination register address |
| rec_rd_wdata | input | 32 | Destination value written |
| rec_pc_rdata | input | 32 | pc of this instruction |
| rec_pc_wdata | input | 32 | pc of the next instruction |
| rec_mem_addr | input | 32 | Memory access address |
| rec_mem_rmask | input | 4 | Read byte-lane mask |
| rec_mem_wmask | input | 4 | Write byte-lane mask |
| err_any | output | 1 | Some flag is set |
| err_flags | output | 10 | Sticky per-rule violation flags |
| err_code | output | 4 | Code of the first violation, 0 if none |
| err_order | output | 64 | Index of the first offending record |

## Verification
Long streams of legal records are generated with random jumps, compressed and full-width words, zero and nonzero register addresses, and masked and unmasked memory accesses. No flag may rise on these, which separates real rule checks from over-eager ones. Single-rule injections after a reset show that each rule raises its own bit and code. A record that breaks two rules at once checks the order of precedence, and a later violation checks that the captured code and index do not move. Garbage presented with the strobe low, a first record with an arbitrary index and a jump, and an index wrap from all-ones to zero separate correct exemptions from missing ones.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NUM_ERR = 10;
  localparam int CODE_W  = 4;
  localparam int MODE_W  = 2;

  // flag bit positions; code = position + 1, lower code has precedence
  localparam int E_ORDER = 0;
  localparam int E_HALT  = 1;
  localparam int E_RS1   = 2;
  localparam int E_RS2   = 3;
  localparam int E_RD    = 4;
  localparam int E_INTR  = 5;
  localparam int E_MODE  = 6;
  localparam int E_IXL   = 7;
  localparam int E_MEM   = 8;
  localparam int E_INSN  = 9;

  localparam logic [MODE_W-1:0] MODE_RSVD = 2'd2;
  localparam logic [MODE_W-1:0] IXL_32    = 2'd1;

  function automatic logic [CODE_W-1:0] first_code(input logic [NUM_ERR-1:0] v);
    logic [CODE_W-1:0] c;
    c = '0;
    for (int i = NUM_ERR - 1; i >= 0; i--) begin
      if (v[i]) c = CODE_W'(i + 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/rtc_field_rules.sv
module rtc_field_rules
  import rtc_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int ILEN   = 32,
  parameter int REG_AW = 5
) (
  input  logic [ILEN-1:0]   insn,
  input  logic [MODE_W-1:0] mode,
  input  logic [MODE_W-1:0] ixl,
  input  logic [REG_AW-1:0] rs1_addr,
  input  logic [XLEN-1:0]   rs1_data,
  input  logic [REG_AW-1:0] rs2_addr,
  input  logic [XLEN-1:0]   rs2_data,
  input  logic [REG_AW-1:0] rd_addr,
  input  logic [XLEN-1:0]   rd_wdata,
  input  logic [XLEN-1:0]   mem_addr,
  input  logic [XLEN/8-1:0] mem_rmask,
  input  logic [XLEN/8-1:0] mem_wmask,
  output logic              bad_rs1,
  output logic              bad_rs2,
  output logic              bad_rd,
  output logic              bad_mode,
  output logic              bad_ixl,
  output logic              bad_mem,
  output logic              bad_insn
);
  localparam int LANES  = XLEN / 8;
  localparam int HALF_W = ILEN / 2;
  localparam logic [XLEN-1:0] LANE_MASK = XLEN'(LANES - 1);

  function automatic logic zero_reg_ok(input logic [REG_AW-1:0] a,
                                       input logic [XLEN-1:0] d);
    return (a != '0) || (d == '0);
  endfunction

  function automatic logic lane_align_ok(input logic [XLEN-1:0] a,
                                         input logic [LANES-1:0] rm,
                                         input logic [LANES-1:0] wm);
    return ((rm | wm) == '0) || ((a & LANE_MASK) == '0);
  endfunction

  function automatic logic short_word_ok(input logic [ILEN-1:0] w);
    return (w[1:0] == 2'b11) || ((w >> HALF_W) == '0);
  endfunction

  always_comb begin
    bad_rs1  = !zero_reg_ok(rs1_addr, rs1_data);
    bad_rs2  = !zero_reg_ok(rs2_addr, rs2_data);
    bad_rd   = !zero_reg_ok(rd_addr, rd_wdata);
    bad_mode = (mode == MODE_RSVD);
    bad_ixl  = (ixl != IXL_32);
    bad_mem  = !lane_align_ok(mem_addr, mem_rmask, mem_wmask);
    bad_insn = !short_word_ok(insn);
  end
endmodule

// File: rtl/rtc_seq_track.sv
module rtc_seq_track #(
  parameter int ORDER_W = 64,
  parameter int XLEN    = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rec_valid,
  input  logic [ORDER_W-1:0] rec_order,
  input  logic               rec_intr,
  input  logic               rec_halt,
  input  logic [XLEN-1:0]    rec_pc_rdata,
  input  logic [XLEN-1:0]    rec_pc_wdata,
  output logic               ord_err,
  output logic               intr_err,
  output logic               halt_err
);
  logic               seen_q;
  logic               halted_q;
  logic [ORDER_W-1:0] expect_q;
  logic [XLEN-1:0]    prev_pcw_q;

  function automatic logic [ORDER_W-1:0] next_index(input logic [ORDER_W-1:0] o);
    return o + ORDER_W'(1);
  endfunction

  always_comb begin
    ord_err  = rec_valid && seen_q && (rec_order != expect_q);
    intr_err = rec_valid && seen_q && (rec_intr != (rec_pc_rdata != prev_pcw_q));
    halt_err = rec_valid && halted_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q     <= 1'b0;
      halted_q   <= 1'b0;
      expect_q   <= '0;
      prev_pcw_q <= '0;
    end else if (rec_valid) begin
      seen_q     <= 1'b1;
      halted_q   <= halted_q | rec_halt;
      expect_q   <= next_index(rec_order);
      prev_pcw_q <= rec_pc_wdata;
    end
  end
endmodule

// File: rtl/rtc_err_latch.sv
module rtc_err_latch
  import rtc_pkg::*;
#(
  parameter int ORDER_W = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_ERR-1:0] viol,
  input  logic [ORDER_W-1:0] rec_order,
  output logic [NUM_ERR-1:0] err_flags,
  output logic [CODE_W-1:0]  err_code,
  output logic [ORDER_W-1:0] err_order
);
  logic capture;
  assign capture = (err_code == '0) && (viol != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      err_flags <= '0;
      err_code  <= '0;
      err_order <= '0;
    end else begin
      err_flags <= err_flags | viol;
      if (capture) begin
        err_code  <= first_code(viol);
        err_order <= rec_order;
      end
    end
  end
endmodule

// File: rtl/retire_trace_checker.sv
module retire_trace_checker
  import rtc_pkg::*;
#(
  parameter int ORDER_W = 64,
  parameter int XLEN    = 32,
  parameter int ILEN    = 32,
  parameter int REG_AW  = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rec_valid,
  input  logic [ORDER_W-1:0] rec_order,
  input  logic [ILEN-1:0]    rec_insn,
  input  logic               rec_halt,
  input  logic               rec_intr,
  input  logic [MODE_W-1:0]  rec_mode,
  input  logic [MODE_W-1:0]  rec_ixl,
  input  logic [REG_AW-1:0]  rec_rs1_addr,
  input  logic [XLEN-1:0]    rec_rs1_data,
  input  logic [REG_AW-1:0]  rec_rs2_addr,
  input  logic [XLEN-1:0]    rec_rs2_data,
  input  logic [REG_AW-1:0]  rec_rd_addr,
  input  logic [XLEN-1:0]    rec_rd_wdata,
  input  logic [XLEN-1:0]    rec_pc_rdata,
  input  logic [XLEN-1:0]    rec_pc_wdata,
  input  logic [XLEN-1:0]    rec_mem_addr,
  input  logic [XLEN/8-1:0]  rec_mem_rmask,
  input  logic [XLEN/8-1:0]  rec_mem_wmask,
  output logic               err_any,
  output logic [NUM_ERR-1:0] err_flags,
  output logic [CODE_W-1:0]  err_code,
  output logic [ORDER_W-1:0] err_order
);
  // named events for the checker module
  logic seq_ord_err, seq_intr_err, seq_halt_err;
  logic fr_rs1, fr_rs2, fr_rd, fr_mode, fr_ixl, fr_mem, fr_insn;
  logic [NUM_ERR-1:0] viol;

  rtc_seq_track #(.ORDER_W(ORDER_W), .XLEN(XLEN)) u_seq (
    .clk(clk), .rst(rst), .rec_valid(rec_valid), .rec_order(rec_order),
    .rec_intr(rec_intr), .rec_halt(rec_halt),
    .rec_pc_rdata(rec_pc_rdata), .rec_pc_wdata(rec_pc_wdata),
    .ord_err(seq_ord_err), .intr_err(seq_intr_err), .halt_err(seq_halt_err)
  );

  rtc_field_rules #(.XLEN(XLEN), .ILEN(ILEN), .REG_AW(REG_AW)) u_fields (
    .insn(rec_insn), .mode(rec_mode), .ixl(rec_ixl),
    .rs1_addr(rec_rs1_addr), .rs1_data(rec_rs1_data),
    .rs2_addr(rec_rs2_addr), .rs2_data(rec_rs2_data),
    .rd_addr(rec_rd_addr), .rd_wdata(rec_rd_wdata),
    .mem_addr(rec_mem_addr), .mem_rmask(rec_mem_rmask), .mem_wmask(rec_mem_wmask),
    .bad_rs1(fr_rs1), .bad_rs2(fr_rs2), .bad_rd(fr_rd), .bad_mode(fr_mode),
    .bad_ixl(fr_ixl), .bad_mem(fr_mem), .bad_insn(fr_insn)
  );

  always_comb begin
    viol         = '0;
    viol[E_ORDER] = seq_ord_err;
    viol[E_HALT]  = seq_halt_err;
    viol[E_INTR]  = seq_intr_err;
    viol[E_RS1]   = rec_valid & fr_rs1;
    viol[E_RS2]   = rec_valid & fr_rs2;
    viol[E_RD]    = rec_valid & fr_rd;
    viol[E_MODE]  = rec_valid & fr_mode;
    viol[E_IXL]   = rec_valid & fr_ixl;
    viol[E_MEM]   = rec_valid & fr_mem;
    viol[E_INSN]  = rec_valid & fr_insn;
  end

  rtc_err_latch #(.ORDER_W(ORDER_W)) u_latch (
    .clk(clk), .rst(rst), .viol(viol), .rec_order(rec_order),
    .err_flags(err_flags), .err_code(err_code), .err_order(err_order)
  );

  assign err_any = |err_flags;
endmodule

// File: rtl/rtc_sva.sv
module rtc_sva
  import rtc_pkg::*;
#(
  parameter int ORDER_W = 64
) (
  input logic               clk,
  input logic               rst,
  input logic               rec_valid,
  input logic [MODE_W-1:0]  rec_mode,
  input logic [MODE_W-1:0]  rec_ixl,
  input logic               ord_err,
  input logic               err_any,
  input logic [NUM_ERR-1:0] err_flags,
  input logic [CODE_W-1:0]  err_code,
  input logic [ORDER_W-1:0] err_order
);
  a_r1_idle_no_change: assert property (@(posedge clk) disable iff (rst)
    !rec_valid |=> $stable(err_flags));

  a_r2_order_flagged: assert property (@(posedge clk) disable iff (rst)
    ord_err |=> err_flags[E_ORDER]);

  a_r6_mode_flagged: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && rec_mode == MODE_RSVD) |=> err_flags[E_MODE]);

  a_r7_ixl_flagged: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && rec_ixl != IXL_32) |=> err_flags[E_IXL]);

  a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
    err_any |=> err_any);

  a_r12_capture_held: assert property (@(posedge clk) disable iff (rst)
    err_any |=> ($stable(err_code) && $stable(err_order)));

  a_r12_code_present: assert property (@(posedge clk) disable iff (rst)
    err_any |-> (err_code != '0));

  a_r12_code_absent: assert property (@(posedge clk) disable iff (rst)
    !err_any |-> (err_code == '0 && err_order == '0));

  a_r13_reset_clears: assert property (@(posedge clk)
    rst |=> (err_flags == '0 && err_code == '0));
endmodule

bind retire_trace_checker rtc_sva #(.ORDER_W(ORDER_W)) u_sva (
  .clk(clk), .rst(rst), .rec_valid(rec_valid), .rec_mode(rec_mode),
  .rec_ixl(rec_ixl), .ord_err(seq_ord_err), .err_any(err_any),
  .err_flags(err_flags), .err_code(err_code), .err_order(err_order)
);

// File: tb/retire_trace_checker_tb.sv
module retire_trace_checker_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        v = 1'b0;
  logic [63:0] ord = '0;
  logic [31:0] insn = 32'h13;
  logic        halt = 1'b0, intr = 1'b0;
  logic [1:0]  mode = 2'd3, ixl = 2'd1;
  logic [4:0]  rs1a = '0, rs2a = '0, rda = '0;
  logic [31:0] rs1d = '0, rs2d = '0, rdw = '0, pcr = '0, pcw = '0, maddr = '0;
  logic [3:0]  rmask = '0, wmask = '0;

  logic        err_any;
  logic [9:0]  err_flags;
  logic [3:0]  err_code;
  logic [63:0] err_order;

  int n_cmp = 0, n_bad = 0;

  // bench model
  bit          m_seen, m_halted;
  logic [63:0] m_last;
  logic [31:0] m_last_pcw;
  logic [9:0]  exp_flags;
  logic [3:0]  exp_code;
  logic [63:0] exp_order;

  always #(CLK_PERIOD / 2) clk = ~clk;

  retire_trace_checker u_dut (
    .clk(clk), .rst(rst), .rec_valid(v), .rec_order(ord), .rec_insn(insn),
    .rec_halt(halt), .rec_intr(intr), .rec_mode(mode), .rec_ixl(ixl),
    .rec_rs1_addr(rs1a), .rec_rs1_data(rs1d), .rec_rs2_addr(rs2a), .rec_rs2_data(rs2d),
    .rec_rd_addr(rda), .rec_rd_wdata(rdw), .rec_pc_rdata(pcr), .rec_pc_wdata(pcw),
    .rec_mem_addr(maddr), .rec_mem_rmask(rmask), .rec_mem_wmask(wmask),
    .err_any(err_any), .err_flags(err_flags), .err_code(err_code), .err_order(err_order)
  );

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check(tag, "flags", 64'(err_flags), 64'(exp_flags));
    check(tag, "code",  64'(err_code),  64'(exp_code));
    check(tag, "order", err_order,      exp_order);
    check(tag, "any",   64'(err_any),   64'(exp_flags != '0));
  endtask

  function automatic string kind_tag(input int k);
    case (k)
      0: return "R2";
      1: return "R10";
      2, 3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      default: return "R9";
    endcase
  endfunction

  // violations the current fields carry, given the model history
  function automatic logic [9:0] ref_viol();
    logic [9:0] r;
    r = '0;
    if (m_seen && (ord != m_last + 64'd1)) r[0] = 1'b1;
    if (m_halted) r[1] = 1'b1;
    if (rs1a == 5'd0 && rs1d != 32'd0) r[2] = 1'b1;
    if (rs2a == 5'd0 && rs2d != 32'd0) r[3] = 1'b1;
    if (rda == 5'd0 && rdw != 32'd0) r[4] = 1'b1;
    if (m_seen && (intr != (pcr != m_last_pcw))) r[5] = 1'b1;
    if (mode == 2'b10) r[6] = 1'b1;
    if (ixl != 2'b01) r[7] = 1'b1;
    if ((rmask != 4'd0 || wmask != 4'd0) && maddr[1:0] != 2'b00) r[8] = 1'b1;
    if (insn[1:0] != 2'b11 && insn[31:16] != 16'd0) r[9] = 1'b1;
    return r;
  endfunction

  task automatic do_reset();
    rst = 1'b1; v = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_seen = 0; m_halted = 0; m_last = '0; m_last_pcw = '0;
    exp_flags = '0; exp_code = '0; exp_order = '0;
  endtask

  // present one record at the current negedge, compare one cycle later
  task automatic issue(input string tag);
    logic [9:0] vv;
    vv = ref_viol();
    exp_flags |= vv;
    if (exp_code == 4'd0 && vv != '0) begin
      for (int i = 9; i >= 0; i--) if (vv[i]) exp_code = 4'(i + 1);
      exp_order = ord;
    end
    m_seen = 1; m_last = ord; m_last_pcw = pcw; m_halted |= halt;
    v = 1'b1;
    @(posedge clk);
    @(negedge clk);
    v = 1'b0;
    compare_all(tag);
  endtask

  task automatic gen_legal();
    logic [31:0] lo;
    ord  = m_seen ? m_last + 64'd1 : {$urandom, $urandom};
    if (($urandom % 4) == 0 || !m_seen) pcr = $urandom & 32'hFFFF_FFFC;
    else pcr = m_last_pcw;
    intr = m_seen ? (pcr != m_last_pcw) : 1'($urandom);
    pcw  = pcr + 32'd4;
    halt = 1'b0;
    rs1a = 5'($urandom); rs1d = (rs1a == 0) ? 32'd0 : $urandom;
    rs2a = 5'($urandom); rs2d = (rs2a == 0) ? 32'd0 : $urandom;
    rda  = 5'($urandom); rdw  = (rda == 0) ? 32'd0 : $urandom;
    case ($urandom % 3)
      0: mode = 2'd0;
      1: mode = 2'd1;
      default: mode = 2'd3;
    endcase
    ixl = 2'd1;
    case ($urandom % 3)
      0: begin rmask = 4'd0; wmask = 4'd0; maddr = $urandom; end
      1: begin rmask = 4'(($urandom % 15) + 1); wmask = 4'd0; maddr = $urandom & 32'hFFFF_FFFC; end
      default: begin rmask = 4'd0; wmask = 4'(($urandom % 15) + 1); maddr = $urandom & 32'hFFFF_FFFC; end
    endcase
    if ($urandom % 2) begin
      lo = $urandom;
      if (lo[1:0] == 2'b11) lo[1:0] = 2'b00;
      insn = {16'd0, lo[15:0]};
    end else begin
      insn = $urandom | 32'd3;
    end
  endtask

  task automatic inject(input int k);
    case (k)
      0: ord = ord + 64'd2;
      1: halt = 1'b1;
      2: begin rs1a = 5'd0; rs1d = $urandom | 32'd1; end
      3: begin rs2a = 5'd0; rs2d = $urandom | 32'd1; end
      4: begin rda = 5'd0; rdw = $urandom | 32'd1; end
      5: intr = ~intr;
      6: mode = 2'd2;
      7: ixl = ($urandom % 2) ? 2'd2 : 2'd0;
      8: begin rmask = 4'b0011; maddr = ($urandom & 32'hFFFF_FFFC) | 32'd2; end
      default: insn = {16'h8001 | 16'($urandom), 14'($urandom), 2'b01};
    endcase
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h0BEE_F00D));
    do_reset();
    compare_all("R13 after reset");

    // R1: garbage with valid low, including a halt mark, changes nothing
    mode = 2'd2; ixl = 2'd0; rs1a = 0; rs1d = 32'hDEAD; halt = 1'b1;
    insn = 32'hFFFF_0000; rmask = 4'hF; maddr = 32'h3;
    repeat (5) @(negedge clk);
    compare_all("R1 idle garbage");
    // first record: arbitrary index and a jump are both exempt (R2, R5)
    gen_legal(); ord = 64'h1234_5678_9ABC_DEF0; intr = 1'b1; pcr = 32'h8000_0000; pcw = pcr + 4;
    issue("R1 first after idle");
    for (int i = 0; i < 8; i++) begin gen_legal(); issue("R2 legal run"); end
    // R2 index wrap
    do_reset();
    gen_legal(); ord = '1; issue("R2 wrap seed");
    gen_legal(); check("R2", "wrap index", ord, 64'd0); issue("R2 wrap to zero");
    // R8 / R9 ignored cases
    gen_legal(); rmask = 0; wmask = 0; maddr = 32'h0000_0007; issue("R8 unmasked address ignored");
    gen_legal(); insn = 32'h0000_4501; issue("R9 short word legal");
    gen_legal(); insn = 32'hFFFF_FFFF; issue("R9 full word unchecked");
    gen_legal(); pcr = m_last_pcw + 32'h40; pcw = pcr + 4; intr = 1'b1; issue("R5 legal jump");

    // single-rule injections
    for (int k = 0; k < 10; k++) begin
      do_reset();
      gen_legal(); issue(kind_tag(k));
      gen_legal();
      if (k == 1) begin
        halt = 1'b1; issue("R10 halt mark");
        gen_legal();
      end else begin
        inject(k);
      end
      issue(kind_tag(k));
      check(kind_tag(k), "own code", 64'(err_code), 64'(k + 1));
      check(kind_tag(k), "own flag", 64'(err_flags[k]), 64'd1);
    end

    // R12 precedence and hold
    do_reset();
    gen_legal(); issue("R12 seed");
    gen_legal(); mode = 2'd2; rda = 0; rdw = 32'h55; issue("R12 two at once");
    check("R12", "lowest code", 64'(err_code), 64'd5);
    gen_legal(); ord = ord + 64'd9; issue("R12 later violation");
    check("R12", "code held", 64'(err_code), 64'd5);
    check("R11", "flags accumulate", 64'(err_flags), 64'h051);
    do_reset();
    compare_all("R13 clears");
    gen_legal(); ord = 64'd77; issue("R13 history forgotten");

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      if (n % 250 == 0) do_reset();
      gen_legal();
      if (($urandom % 100) < 4) inject(int'($urandom % 10));
      issue("R11 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule